// File: doc/BRIEF.md
# Steerable Watchdog Timer

This block supervises a host processor. Software programs a single 8-bit control byte that chooses a timeout length and where a timeout goes. The timeout length is a 5-bit multiplier times one of four resolution steps. The time base is an enable pulse at 1/16 second. Every host read or write of the control byte counts as proof of life and starts the count again. If software stays silent for the whole timeout, the block takes one of two actions. It can latch a flag and raise an interrupt request. Or it can emit a reset request that lasts a fixed number of ticks, and in that case it also clears the control byte and asks the surrounding logic to clear its frequency-test bit.

The interrupt line is shared with a frequency-test mode. When the test bit is set, the alarm-enable bit is clear, and the watchdog is either steered to reset or switched off, the line carries a 512 Hz square wave. That wave is built by toggling on a 1024 Hz enable. When the watchdog is steered to the interrupt, the watchdog has priority and the square wave is held off. Pad drivers and pin polarity belong to the surrounding logic: every output here is active-high.

Top module: `wdog_steer`

## Requirements
- R1: After reset, wdReg reads 8'h00 and wdFlag, irqOut, rstReq and ftClear are all 0.
- R2: Control byte layout: bit 7 is the steering bit (0 = interrupt, 1 = reset), bits 6:2 are the multiplier M, and bits 1:0 are the resolution code. The codes are 00 = 1 tick, 01 = 4 ticks, 10 = 16 ticks and 11 = 64 ticks. A timeout occurs on exactly the M×step-th tickEn pulse after the last restart, and not on any earlier one.
- R3: A regRdEn or regWrEn pulse clears the elapsed tick count, so the timeout window starts again from that access.
- R4: If the multiplier field is zero (including the value 8'h00), the watchdog never times out, whatever the resolution code is.
- R5: With steering 0, a timeout sets wdFlag, and irqOut is 1 in the cycle that follows the clock edge of the final tick. rstReq stays 0.
- R6: wdFlag is cleared by flagRdEn, by regRdEn or by regWrEn. A timeout in the same cycle as a flag read leaves wdFlag set.
- R7: With steering 1, a timeout raises rstReq for exactly PULSE_TICKS tickEn pulses (default 2) and does not set wdFlag.
- R8: With steering 1, a timeout clears wdReg to 8'h00 and raises ftClear for exactly one cycle. After that the watchdog stays idle.
- R9: While ftBit=1, aeBit=0 and either the steering bit is 1 or wdReg is 8'h00, irqOut starts at 0 and toggles on every ftTickEn pulse. With aeBit=1 it stays 0.
- R10: While the steering bit is 0 and wdReg is nonzero, a frequency-test request is ignored. irqOut stays 0 before a timeout and stays at a steady 1 after one.
- R11: A register access in the same cycle as the final tick wins: no timeout occurs, and the next full window is counted from that access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tickEn | input | 1 | 1/16-second time-base enable, one cycle wide |
| ftTickEn | input | 1 | 1024 Hz toggle enable for the test square wave |
| regWrEn | input | 1 | Host write strobe for the control byte |
| regWrData | input | 8 | Write data for the control byte |
| regRdEn | input | 1 | Host read strobe for the control byte |
| flagRdEn | input | 1 | Host read strobe for the flags byte (clears wdFlag) |
| ftBit | input | 1 | Frequency-test request bit |
| aeBit | input | 1 | Alarm-enable bit, which blocks frequency test |
| wdReg | output | 8 | Current control byte, for readback |
| wdFlag | output | 1 | Watchdog timeout flag |
| irqOut | output | 1 | Shared interrupt / frequency-test line |
| rstReq | output | 1 | Timed reset request |
| ftClear | output | 1 | One-cycle request to clear the frequency-test bit |

## Verification
Timeout length is swept over all four resolution codes, each with several multipliers. Each pair is checked one tick before expiry and on the expiring tick, which separates an off-by-one count from a wrong resolution scale. Restart is tried with a read, with a write, and with an access that coincides with the final tick, which shows whether access or expiry has priority. The shared line is driven with every combination that matters: steering 1, a zero control byte, alarm enable set, and an interrupt-steered byte both before and after its timeout. This separates the square wave from the level interrupt and from silence.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int MULT_W = 5;
  localparam int RES_W  = 2;
  localparam int REG_W  = 1 + MULT_W + RES_W;

  typedef struct packed {
    logic cntClear;   // restart the tick count
    logic cntRun;     // a nonzero multiplier is programmed
    logic pulseLoad;  // start the reset pulse
    logic sqRun;      // frequency-test wave allowed
  } wdStrobe_t;
endpackage

// File: rtl/wdog_dp.sv
module wdog_dp
  import wdog_pkg::*;
#(
  parameter int PULSE_TICKS = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              ftTickEn,
  input  wdStrobe_t         strobe,
  input  logic [MULT_W-1:0] mult,
  input  logic [RES_W-1:0]  resSel,
  output logic              expire,
  output logic              pulseActive,
  output logic              sqWave
);
  localparam int MAX_SHIFT = 2 * ((1 << RES_W) - 1);
  localparam int CNT_W     = MULT_W + MAX_SHIFT;
  localparam int PCNT_W    = $clog2(PULSE_TICKS + 1);

  logic [CNT_W-1:0]  tickCnt;
  logic [CNT_W-1:0]  limit;
  logic [PCNT_W-1:0] pulseCnt;

  // timeout in ticks: multiplier scaled by 4^resSel
  assign limit  = CNT_W'(mult) << (2 * resSel);
  assign expire = tickEn && strobe.cntRun && (tickCnt == limit - CNT_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tickCnt <= '0;
    end else if (strobe.cntClear || !strobe.cntRun) begin
      tickCnt <= '0;
    end else if (tickEn) begin
      tickCnt <= expire ? '0 : tickCnt + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pulseCnt <= '0;
    end else if (strobe.pulseLoad) begin
      pulseCnt <= PCNT_W'(PULSE_TICKS);
    end else if (tickEn && pulseCnt != '0) begin
      pulseCnt <= pulseCnt - PCNT_W'(1);
    end
  end

  assign pulseActive = (pulseCnt != '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sqWave <= 1'b0;
    end else if (!strobe.sqRun) begin
      sqWave <= 1'b0;
    end else if (ftTickEn) begin
      sqWave <= ~sqWave;
    end
  end

  a_r2_cnt_below_limit : assert property (@(posedge clk) disable iff (!rstN)
    strobe.cntRun |-> (tickCnt < limit))
    else $error("tick count reached limit without expiring");

  a_r7_pulse_bounded : assert property (@(posedge clk) disable iff (!rstN)
    pulseCnt <= PCNT_W'(PULSE_TICKS))
    else $error("reset pulse counter overrun");

  a_r7_pulse_starts : assert property (@(posedge clk) disable iff (!rstN)
    strobe.pulseLoad |=> pulseActive)
    else $error("reset pulse did not start");
endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [REG_W-1:0] regWrData,
  input  logic             regRdEn,
  input  logic             flagRdEn,
  input  logic             ftBit,
  input  logic             aeBit,
  input  logic             expire,
  output logic [REG_W-1:0] wdReg,
  output logic             wdFlag,
  output logic             ftClear,
  output wdStrobe_t        strobe
);
  logic access;
  logic steerRst;
  logic timeoutHit;
  logic ftMode;

  assign access     = regWrEn || regRdEn;
  assign steerRst   = wdReg[REG_W-1];
  // an access that coincides with the final tick wins over it
  assign timeoutHit = expire && !access;
  assign ftMode     = ftBit && !aeBit && (steerRst || wdReg == '0);

  always_comb begin
    strobe.cntClear  = access;
    strobe.cntRun    = (wdReg[REG_W-2:RES_W] != '0);
    strobe.pulseLoad = timeoutHit && steerRst;
    strobe.sqRun     = ftMode;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wdReg <= '0;
    end else if (regWrEn) begin
      wdReg <= regWrData;
    end else if (timeoutHit && steerRst) begin
      wdReg <= '0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wdFlag <= 1'b0;
    end else if (timeoutHit && !steerRst) begin
      wdFlag <= 1'b1;
    end else if (access || flagRdEn) begin
      wdFlag <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ftClear <= 1'b0;
    end else begin
      ftClear <= timeoutHit && steerRst;
    end
  end

  a_r5_flag_only_irq_steer : assert property (@(posedge clk) disable iff (!rstN)
    $rose(wdFlag) |-> !$past(wdReg[REG_W-1]))
    else $error("flag set while steered to reset");

  a_r8_reg_cleared : assert property (@(posedge clk) disable iff (!rstN)
    strobe.pulseLoad |=> (wdReg == '0) && ftClear)
    else $error("reset-steered timeout left register set");

  a_r11_access_blocks_timeout : assert property (@(posedge clk) disable iff (!rstN)
    access |=> !ftClear && !$rose(wdFlag))
    else $error("timeout taken despite access");
endmodule

// File: rtl/wdog_steer.sv
module wdog_steer
  import wdog_pkg::*;
#(
  parameter int PULSE_TICKS = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickEn,
  input  logic             ftTickEn,
  input  logic             regWrEn,
  input  logic [REG_W-1:0] regWrData,
  input  logic             regRdEn,
  input  logic             flagRdEn,
  input  logic             ftBit,
  input  logic             aeBit,
  output logic [REG_W-1:0] wdReg,
  output logic             wdFlag,
  output logic             irqOut,
  output logic             rstReq,
  output logic             ftClear
);
  wdStrobe_t strobe;
  logic      expire;
  logic      sqWave;

  wdog_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .regWrEn   (regWrEn),
    .regWrData (regWrData),
    .regRdEn   (regRdEn),
    .flagRdEn  (flagRdEn),
    .ftBit     (ftBit),
    .aeBit     (aeBit),
    .expire    (expire),
    .wdReg     (wdReg),
    .wdFlag    (wdFlag),
    .ftClear   (ftClear),
    .strobe    (strobe)
  );

  wdog_dp #(.PULSE_TICKS(PULSE_TICKS)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .tickEn      (tickEn),
    .ftTickEn    (ftTickEn),
    .strobe      (strobe),
    .mult        (wdReg[REG_W-2:RES_W]),
    .resSel      (wdReg[RES_W-1:0]),
    .expire      (expire),
    .pulseActive (rstReq),
    .sqWave      (sqWave)
  );

  // the flag dominates; the wave only runs when the watchdog allows it
  assign irqOut = wdFlag || sqWave;

  a_r10_flag_drives_line : assert property (@(posedge clk) disable iff (!rstN)
    wdFlag |-> irqOut)
    else $error("flag set but line low");

  a_r7_no_flag_and_pulse_start : assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstReq) |-> !$rose(wdFlag))
    else $error("both timeout actions at once");
endmodule

// File: tb/wdog_steer_tb.sv
module wdog_steer_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tickEn = 1'b0;
  logic       ftTickEn = 1'b0;
  logic       regWrEn = 1'b0;
  logic [7:0] regWrData = 8'h00;
  logic       regRdEn = 1'b0;
  logic       flagRdEn = 1'b0;
  logic       ftBit = 1'b0;
  logic       aeBit = 1'b0;
  logic [7:0] wdReg;
  logic       wdFlag, irqOut, rstReq, ftClear;

  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdog_steer u_dut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .ftTickEn(ftTickEn),
    .regWrEn(regWrEn), .regWrData(regWrData), .regRdEn(regRdEn),
    .flagRdEn(flagRdEn), .ftBit(ftBit), .aeBit(aeBit),
    .wdReg(wdReg), .wdFlag(wdFlag), .irqOut(irqOut),
    .rstReq(rstReq), .ftClear(ftClear)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tickEn = 1'b1;
      @(negedge clk) tickEn = 1'b0;
    end
  endtask

  task automatic wrReg(input logic [7:0] v);
    @(negedge clk) begin regWrEn = 1'b1; regWrData = v; end
    @(negedge clk) regWrEn = 1'b0;
  endtask

  task automatic rdReg();
    @(negedge clk) regRdEn = 1'b1;
    @(negedge clk) regRdEn = 1'b0;
  endtask

  task automatic rdFlag();
    @(negedge clk) flagRdEn = 1'b1;
    @(negedge clk) flagRdEn = 1'b0;
  endtask

  task automatic ftPulse();
    @(negedge clk) ftTickEn = 1'b1;
    @(negedge clk) ftTickEn = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int mults[4] = '{1, 2, 5, 31};
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 wdReg", wdReg, 0);
    chk("R1 flag", wdFlag, 0);
    chk("R1 irq", irqOut, 0);
    chk("R1 rstReq", rstReq, 0);
    chk("R1 ftClear", ftClear, 0);

    // R2 and R5 sweep over resolution and multiplier, steering to interrupt
    for (int r = 0; r < 4; r++) begin
      for (int m = 0; m < 4; m++) begin
        int n;
        n = mults[m] * (1 << (2 * r));
        wrReg(8'((mults[m] << 2) | r));
        tick(n - 1);
        chk($sformatf("R2 early m=%0d r=%0d", mults[m], r), wdFlag, 0);
        tick(1);
        chk($sformatf("R2 expire m=%0d r=%0d", mults[m], r), wdFlag, 1);
        chk("R5 irq", irqOut, 1);
        chk("R5 no rst", rstReq, 0);
        rdFlag();
        chk("R6 flag read clears", wdFlag, 0);
      end
    end

    // R3 restart by read, then by write (4-tick window)
    wrReg(8'h05);
    tick(3); rdReg(); tick(3);
    chk("R3 read restarts", wdFlag, 0);
    tick(1);
    chk("R3 expire after read", wdFlag, 1);
    wrReg(8'h05);
    chk("R6 write clears", wdFlag, 0);
    tick(3); wrReg(8'h05); tick(3);
    chk("R3 write restarts", wdFlag, 0);
    tick(1);
    chk("R3 expire after write", wdFlag, 1);
    rdReg();
    chk("R6 reg read clears", wdFlag, 0);
    chk("R6 irq low", irqOut, 0);

    // R6 set beats clear
    tick(3);
    @(negedge clk) begin tickEn = 1'b1; flagRdEn = 1'b1; end
    @(negedge clk) begin tickEn = 1'b0; flagRdEn = 1'b0; end
    chk("R6 set beats clear", wdFlag, 1);
    rdFlag();

    // R11 access on the final tick
    rdReg();
    tick(3);
    @(negedge clk) begin tickEn = 1'b1; regRdEn = 1'b1; end
    @(negedge clk) begin tickEn = 1'b0; regRdEn = 1'b0; end
    chk("R11 access wins", wdFlag, 0);
    tick(3);
    chk("R11 new window early", wdFlag, 0);
    tick(1);
    chk("R11 new window expire", wdFlag, 1);

    // R4 zero multiplier disables
    wrReg(8'h00);
    tick(100);
    chk("R4 00h idle", wdFlag, 0);
    wrReg(8'h03);
    tick(100);
    chk("R4 zero mult idle", wdFlag, 0);
    chk("R4 no rst", rstReq, 0);

    // R7 and R8 reset steering (0x85: steer 1, M=1, 4 ticks)
    wrReg(8'h85);
    tick(3);
    chk("R7 no early pulse", rstReq, 0);
    tick(1);
    chk("R7 pulse high", rstReq, 1);
    chk("R7 no flag", wdFlag, 0);
    chk("R8 reg cleared", wdReg, 0);
    chk("R8 ftClear high", ftClear, 1);
    @(negedge clk);
    chk("R8 ftClear one cycle", ftClear, 0);
    tick(1);
    chk("R7 pulse after 1 tick", rstReq, 1);
    tick(1);
    chk("R7 pulse ends", rstReq, 0);
    tick(20);
    chk("R8 stays idle", rstReq, 0);
    chk("R8 reg stays 0", wdReg, 0);

    // R9 frequency test with zero register
    ftBit = 1'b1; aeBit = 1'b0;
    @(negedge clk);
    chk("R9 wave starts low", irqOut, 0);
    for (int k = 1; k <= 6; k++) begin
      ftPulse();
      chk($sformatf("R9 toggle reg0 k=%0d", k), irqOut, k % 2);
    end
    // R9 frequency test with steering 1
    wrReg(8'hFF);
    chk("R9 steer1 start", irqOut, 0);
    for (int k = 1; k <= 4; k++) begin
      ftPulse();
      chk($sformatf("R9 toggle steer1 k=%0d", k), irqOut, k % 2);
    end
    // R9 alarm enable blocks
    aeBit = 1'b1;
    wrReg(8'h00);
    for (int k = 1; k <= 3; k++) begin
      ftPulse();
      chk("R9 ae blocks", irqOut, 0);
    end
    aeBit = 1'b0;

    // R10 watchdog steered to interrupt wins
    wrReg(8'h05);
    for (int k = 1; k <= 3; k++) begin
      ftPulse();
      chk("R10 no wave before timeout", irqOut, 0);
    end
    tick(4);
    for (int k = 1; k <= 3; k++) begin
      ftPulse();
      chk("R10 steady after timeout", irqOut, 1);
    end
    ftBit = 1'b0;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule